// File: doc/BRIEF.md
# Burst Request Legality Checker

This block sits in front of a memory-mapped bus master and decides whether a requested burst is legal before any address beat goes out. A request consists of a start byte address, a number of beats, a beat size in bytes and a burst kind. The block checks the request against the length rules for its burst kind, the beat-size rules for the configured data width, and the 4 KB page rule for incrementing bursts. It returns an accept flag and a two-bit reason code, together with the encoded length, size and burst fields for the address channel.

The request side is a single-cycle strobe. The block has no back-pressure: it takes one request on every cycle in which the strobe is high. Each result appears one cycle later together with a one-cycle result strobe. When no request arrives, the result fields keep their last values. A synchronous active-high reset clears the accept flag and the result strobe.

Top module: `axb_req_check`

## Requirements
- R1: During and directly after a synchronous reset, `rsp_valid` and `rsp_accept` are 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. When `req_valid` is low, all result fields keep their values.
- R3: A beat count of zero is rejected with reason 1 (bad length).
- R4: Incrementing bursts (kind 2'b01) accept 1 to 256 beats, and fixed bursts (kind 2'b00) accept 1 to 16 beats. A larger count is rejected with reason 1.
- R5: Wrapping bursts (kind 2'b10) are accepted only with 1, 2, 4, 8 or 16 beats. Any other count is rejected with reason 1.
- R6: Burst kind 2'b11 is always rejected with reason 1.
- R7: A beat size that is zero, not a power of two, or larger than DATA_W/8 bytes is rejected with reason 2.
- R8: An incrementing burst is rejected with reason 3 when address bits 12 and above differ between the start address and start + size*(beats-1). Fixed and wrapping bursts are never rejected for this.
- R9: When several violations apply, the lowest nonzero reason (1, then 2, then 3) is reported.
- R10: `ax_len` is beats-1 in 8 bits, `ax_size` is log2 of a legal beat size, and `ax_burst` repeats the requested kind.
- R11: `rsp_accept` is 1 exactly when the reason is 0 (accepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_beats | input | CNT_W | Number of beats |
| req_size | input | SIZE_W | Bytes per beat |
| req_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_accept | output | 1 | Request is legal |
| rsp_reason | output | 2 | 0 ok, 1 bad length, 2 bad size, 3 page crossing |
| ax_len | output | 8 | Encoded beats minus one |
| ax_size | output | 3 | Encoded log2 of the beat size |
| ax_burst | output | 2 | Encoded burst kind |

## Verification
The bench drives length limits on both sides of each edge: 256 and 257 incrementing beats, 16 and 17 fixed beats, and legal and illegal wrapping counts. A design with an off-by-one limit would accept a request it must reject, or reject one it must accept. It places incrementing bursts so that the last beat lands exactly on the next page or just below it, and places a fixed burst across the same page edge. A design that tested the end address instead of the last beat address, or applied the page rule to every burst kind, would give the wrong reason. Requests with two violations at once catch a wrong priority order. Idle cycles after a request catch a result that does not hold, or a strobe that stays high.

// File: rtl/axb_pkg.sv
package axb_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  typedef enum logic [1:0] {
    RC_OK   = 2'd0,
    RC_LEN  = 2'd1,
    RC_SIZE = 2'd2,
    RC_PAGE = 2'd3
  } reason_e;

  localparam int PAGE_LSB  = 12;
  localparam int AXLEN_W   = 8;
  localparam int AXSIZE_W  = 3;
  localparam int INCR_MAX  = 256;
  localparam int FIXED_MAX = 16;
  localparam int WRAP_MAX  = 16;
endpackage

// File: rtl/axb_len_rule.sv
module axb_len_rule
  import axb_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] beats,
  input  logic [1:0]       kind,
  output logic             len_ok
);
  localparam logic [CNT_W-1:0] LIM_INCR  = CNT_W'(INCR_MAX);
  localparam logic [CNT_W-1:0] LIM_FIXED = CNT_W'(FIXED_MAX);
  localparam logic [CNT_W-1:0] LIM_WRAP  = CNT_W'(WRAP_MAX);

  logic nonzero;
  logic pow2;

  assign nonzero = (beats != '0);
  assign pow2    = ($countones(beats) == 1);

  always_comb begin
    unique case (burst_kind_e'(kind))
      BK_INCR:  len_ok = nonzero && (beats <= LIM_INCR);
      BK_FIXED: len_ok = nonzero && (beats <= LIM_FIXED);
      BK_WRAP:  len_ok = pow2 && (beats <= LIM_WRAP);
      default:  len_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/axb_size_rule.sv
module axb_size_rule
  import axb_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int DATA_W = 64
) (
  input  logic [SIZE_W-1:0]   size_bytes,
  output logic                size_ok,
  output logic [AXSIZE_W-1:0] size_enc
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam logic [SIZE_W-1:0] BUS_LIM = SIZE_W'(BUS_BYTES);

  assign size_ok = ($countones(size_bytes) == 1) && (size_bytes <= BUS_LIM);

  // highest set bit; equals log2 whenever the size is a power of two
  always_comb begin
    size_enc = '0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (size_bytes[i]) size_enc = AXSIZE_W'(i);
    end
  end
endmodule

// File: rtl/axb_page_rule.sv
module axb_page_rule
  import axb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    beats,
  input  logic [AXSIZE_W-1:0] size_enc,
  output logic                crosses
);
  localparam int SPAN_W = CNT_W + (1 << AXSIZE_W);
  localparam int SUM_W  = ((ADDR_W > SPAN_W) ? ADDR_W : SPAN_W) + 1;

  logic [SPAN_W-1:0] span;
  logic [SUM_W-1:0]  first_ext;
  logic [SUM_W-1:0]  last_ext;

  // size is a power of two when this result matters, so a shift replaces a multiply
  assign span      = SPAN_W'(beats - CNT_W'(1)) << size_enc;
  assign first_ext = SUM_W'(addr);
  assign last_ext  = first_ext + SUM_W'(span);
  assign crosses   = (first_ext[SUM_W-1:PAGE_LSB] != last_ext[SUM_W-1:PAGE_LSB]);
endmodule

// File: rtl/axb_req_check.sv
module axb_req_check
  import axb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9,
  parameter int SIZE_W = 8,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CNT_W-1:0]    req_beats,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [1:0]          req_burst,
  output logic                rsp_valid,
  output logic                rsp_accept,
  output logic [1:0]          rsp_reason,
  output logic [AXLEN_W-1:0]  ax_len,
  output logic [AXSIZE_W-1:0] ax_size,
  output logic [1:0]          ax_burst
);
  logic                len_ok;
  logic                size_ok;
  logic [AXSIZE_W-1:0] size_enc;
  logic                crosses;
  logic                is_incr;
  reason_e             reason_d;
  logic                accept_d;

  axb_len_rule #(.CNT_W(CNT_W)) u_len (
    .beats  (req_beats),
    .kind   (req_burst),
    .len_ok (len_ok)
  );

  axb_size_rule #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_size (
    .size_bytes (req_size),
    .size_ok    (size_ok),
    .size_enc   (size_enc)
  );

  axb_page_rule #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_page (
    .addr     (req_addr),
    .beats    (req_beats),
    .size_enc (size_enc),
    .crosses  (crosses)
  );

  assign is_incr  = (req_burst == BK_INCR);
  assign accept_d = len_ok && size_ok && !(is_incr && crosses);

  always_comb begin
    if (!len_ok)                 reason_d = RC_LEN;
    else if (!size_ok)           reason_d = RC_SIZE;
    else if (is_incr && crosses) reason_d = RC_PAGE;
    else                         reason_d = RC_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_reason <= RC_OK;
      ax_len     <= '0;
      ax_size    <= '0;
      ax_burst   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_accept <= accept_d;
        rsp_reason <= reason_d;
        ax_len     <= AXLEN_W'(req_beats - CNT_W'(1));
        ax_size    <= size_enc;
        ax_burst   <= req_burst;
      end
    end
  end

  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_accept));

  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(ax_len) && $stable(rsp_reason) && $stable(rsp_accept)));

  assert_zero_beats_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_beats == '0) |=> (!rsp_accept && rsp_reason == RC_LEN));

  assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_burst == BK_RSVD) |=> (!rsp_accept && rsp_reason == RC_LEN));

  assert_accept_code_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_accept == (rsp_reason == RC_OK)));
endmodule

// File: tb/axb_req_check_bench.sv
module axb_req_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 9;
  localparam int SIZE_W = 8;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_beats = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic [1:0]        req_burst = '0;
  logic              rsp_valid;
  logic              rsp_accept;
  logic [1:0]        rsp_reason;
  logic [7:0]        ax_len;
  logic [2:0]        ax_size;
  logic [1:0]        ax_burst;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axb_req_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_axb_req_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .req_size(req_size), .req_burst(req_burst),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason),
    .ax_len(ax_len), .ax_size(ax_size), .ax_burst(ax_burst)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request, then read the result in the following cycle
  task automatic run_req(string tag, int addr, int beats, int size, int kind,
                         int exp_acc, int exp_rc, int exp_sz);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_beats = CNT_W'(beats);
    req_size  = SIZE_W'(size);
    req_burst = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 strobe"}, int'(rsp_valid), 1);
    check({tag, " R11 accept"}, int'(rsp_accept), exp_acc);
    check({tag, " reason"}, int'(rsp_reason), exp_rc);
    check({tag, " R10 len"}, int'(ax_len), (beats - 1) & 255);
    check({tag, " R10 burst"}, int'(ax_burst), kind);
    if (exp_sz >= 0) check({tag, " R10 size"}, int'(ax_size), exp_sz);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", int'(rsp_valid), 0);
    check("R1 accept in reset", int'(rsp_accept), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(rsp_valid), 0);
    check("R1 accept after reset", int'(rsp_accept), 0);
  endtask

  task automatic t_incr_len();
    run_req("R4 incr 256", 0, 256, 8, 1, 1, 0, 3);
    run_req("R4 incr 257", 0, 257, 8, 1, 0, 1, 3);
    run_req("R4 incr 1 narrow", 32'h100, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_fixed_len();
    run_req("R4 fixed 16", 32'h40, 16, 4, 0, 1, 0, 2);
    run_req("R4 fixed 17", 32'h40, 17, 4, 0, 0, 1, 2);
  endtask

  task automatic t_wrap_len();
    run_req("R5 wrap 8", 32'h80, 8, 8, 2, 1, 0, 3);
    run_req("R5 wrap 1", 32'h80, 1, 2, 2, 1, 0, 1);
    run_req("R5 wrap 3", 32'h80, 3, 8, 2, 0, 1, -1);
    run_req("R5 wrap 32", 32'h80, 32, 8, 2, 0, 1, -1);
  endtask

  task automatic t_zero_and_rsvd();
    run_req("R3 zero beats", 0, 0, 4, 1, 0, 1, -1);
    run_req("R6 reserved kind", 0, 1, 4, 3, 0, 1, -1);
  endtask

  task automatic t_size();
    run_req("R7 size 3", 0, 4, 3, 1, 0, 2, -1);
    run_req("R7 size 16 over bus", 0, 4, 16, 1, 0, 2, -1);
    run_req("R7 size 0", 0, 4, 0, 1, 0, 2, -1);
  endtask

  task automatic t_page();
    run_req("R8 incr cross", 32'hFF8, 2, 8, 1, 0, 3, 3);
    run_req("R8 incr just below", 32'hFF0, 2, 8, 1, 1, 0, 3);
    run_req("R8 fixed no page rule", 32'hFF8, 2, 8, 0, 1, 0, 3);
    run_req("R8 wrap no page rule", 32'h1FF8, 4, 8, 2, 1, 0, 3);
  endtask

  task automatic t_priority();
    run_req("R9 len over size", 0, 0, 3, 1, 0, 1, -1);
    run_req("R9 size over page", 32'hFFF, 8, 6, 1, 0, 2, -1);
    run_req("R9 len over page", 32'hFF8, 300, 8, 1, 0, 1, -1);
  endtask

  task automatic t_hold();
    run_req("R2 base", 32'h200, 5, 4, 1, 1, 0, 2);
    @(negedge clk);
    req_beats = CNT_W'(0);
    req_burst = 2'd3;
    req_size  = SIZE_W'(3);
    repeat (3) @(negedge clk);
    check("R2 idle strobe", int'(rsp_valid), 0);
    check("R2 hold len", int'(ax_len), 4);
    check("R2 hold accept", int'(rsp_accept), 1);
    check("R2 hold reason", int'(rsp_reason), 0);
    check("R2 hold burst", int'(ax_burst), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_incr_len();
    t_fixed_len();
    t_wrap_len();
    t_zero_and_rsvd();
    t_size();
    t_page();
    t_priority();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule